// File: doc/BRIEF.md
# SDRAM Burst Interrupt Command Sequencer

This block sits on the controller side of a four-bank synchronous DRAM. A host hands it one request at a time: activate, read, write, burst stop, precharge, or mode-register set. The block turns each request into a command on the DRAM command bus. The command appears there, with its bank and address, one clock after the host handshake completes.

The block keeps its own copy of the programmed burst length, CAS latency and row-precharge time. It counts write beats and read beats, and it raises a per-cycle flag for each read word that is expected to return on the data bus.

When the host cuts a burst short, the block works out what that means for the DRAM:
- A burst stop during a write masks the beat that would follow.
- A precharge waits until write recovery has passed.
- A read cut short by a stop or a precharge still yields one trailing word at CAS latency 2, or two at CAS latency 3, and nothing after them.

Mode programming is only let through once every bank is closed and the precharge time has run out. The first activate after it is spaced two clocks later.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset the bus carries NOP ({cs_n,ras_n,cas_n,we_n}=0111), `sd_dqm`, `wr_beat` and `rd_valid` are low, `bank_open` is 0, and a mode-set request is ready. The reset mode is CAS latency `RST_CL`, burst code `RST_BL_CODE` and precharge time `RST_TRP`.
- R2: Host codes on `req_cmd` are: 1 activate, 2 read, 3 write, 4 burst stop, 5 precharge, 6 mode set, and 0 or 7 no operation. An accepted request (`req_valid` and `req_ready`) appears on the bus in the next cycle, with `req_bank` on `sd_ba` and `req_addr` on `sd_addr`. The bus encodings are: activate 0011, read 0101, write 0100, precharge 0010, burst stop 0110, mode set 0000, NOP 0111.
- R3: Bit b of `bank_open` is set by an activate to bank b. A precharge clears bit b when address bit 10 is 0, and clears all four bits when address bit 10 is 1.
- R4: A mode set latches three fields:
  - burst length from address bits [1:0] (0,1,2,3 give 1,2,4,8);
  - CAS latency from bit 4 (0 gives 2, 1 gives 3);
  - precharge time in clocks from bits [11:8].
  Reads and writes issued later use these values.
- R5: A mode set is held not-ready while any bank is open. With a precharge on the bus in cycle P, the mode set reaches the bus no earlier than P plus the precharge time.
- R6: With a mode set on the bus in cycle M, an activate reaches the bus no earlier than M+2.
- R7: A write on the bus in cycle T raises `wr_beat` in cycles T to T+BL-1. A precharge requested during the burst reaches the bus no earlier than T+BL, one clock after the last beat.
- R8: A burst stop is accepted at any time, for every burst length. When it lands in cycle S while write beats remain, `wr_beat` is low from S on and `sd_dqm` is high in cycle S.
- R9: A read on the bus in cycle T raises `rd_valid` in cycles T+CL to T+CL+BL-1.
- R10: A read cut short by a burst stop or precharge in cycle S yields `rd_valid` in cycles T+CL up to S+CL-1 only. That is CL-1 words after the interrupting command: 1 at CAS latency 2, 2 at CAS latency 3.
- R11: Read, write, activate and mode-set requests are held not-ready while a read or write burst is running, and NOP is driven while a request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_cmd | input | 3 | Host request code |
| req_bank | input | 2 | Target bank |
| req_addr | input | ADDR_W | Row, column, precharge-all flag or mode fields |
| req_ready | output | 1 | Request can be taken this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address lines |
| sd_dqm | output | 1 | Data mask |
| wr_beat | output | 1 | Host write data is taken this cycle |
| rd_valid | output | 1 | Read word expected on the data bus this cycle |
| bank_open | output | 4 | Open/closed state per bank |

## Verification
The bench builds the block with a 13-bit address and a reset precharge time of three clocks. The first precharge-to-mode-set gap is therefore three rather than the programmed two, and the all-banks flag and mode fields are shown to sit at fixed bit positions independent of width.

Starting from the reset mode (burst 4, CAS latency 3), it reprograms to burst 8 with CAS latency 2, and later to burst 1 with CAS latency 3. This exercises:
- truncation by precharge at CAS latency 3, leaving two trailing words;
- truncation by stop at CAS latency 2, leaving one trailing word;
- a stopped burst-8 write with its masked beat;
- the earliest legal precharge after a full burst-8 write.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int ADDR_W      = 12,
  parameter int MRD_CLKS    = 2,
  parameter int RST_CL      = 3,
  parameter int RST_BL_CODE = 2,
  parameter int RST_TRP     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [1:0]        req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_dqm,
  output logic              wr_beat,
  output logic              rd_valid,
  output logic [3:0]        bank_open
);
  localparam int MRD_W = $clog2(MRD_CLKS + 1);

  localparam logic [2:0] CMD_ACT = 3'd1, CMD_RD = 3'd2, CMD_WR = 3'd3,
                         CMD_BST = 3'd4, CMD_PRE = 3'd5, CMD_MRS = 3'd6;

  localparam logic [3:0] BUS_NOP = 4'b0111, BUS_ACT = 4'b0011, BUS_RD = 4'b0101,
                         BUS_WR = 4'b0100, BUS_PRE = 4'b0010, BUS_BST = 4'b0110,
                         BUS_MRS = 4'b0000;

  logic [3:0]       bus_q;
  logic             cl3_q;
  logic [1:0]       bl_code_q;
  logic [3:0]       trp_q;
  logic [3:0]       rd_left, wr_left, trp_cnt;
  logic [MRD_W-1:0] mrd_cnt;
  logic [2:0]       rd_pipe;
  logic [3:0]       burst_len;
  logic             idle, acc;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = bus_q;
  assign burst_len = 4'd1 << bl_code_q;
  assign idle      = (rd_left == 4'd0) && (wr_left == 4'd0);
  assign wr_beat   = (wr_left != 4'd0);
  assign rd_valid  = cl3_q ? rd_pipe[2] : rd_pipe[1];
  assign acc       = req_valid && req_ready;

  always_comb begin
    case (req_cmd)
      CMD_ACT: req_ready = idle && (trp_cnt <= 4'd1) && (mrd_cnt <= MRD_W'(1));
      CMD_RD,
      CMD_WR:  req_ready = idle;
      CMD_PRE: req_ready = (wr_left <= 4'd1);
      CMD_MRS: req_ready = idle && (bank_open == 4'd0) && (trp_cnt <= 4'd1);
      default: req_ready = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q     <= BUS_NOP;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dqm    <= 1'b0;
      bank_open <= '0;
      cl3_q     <= (RST_CL == 3);
      bl_code_q <= 2'(RST_BL_CODE);
      trp_q     <= 4'(RST_TRP);
      rd_left   <= '0;
      wr_left   <= '0;
      trp_cnt   <= '0;
      mrd_cnt   <= '0;
      rd_pipe   <= '0;
    end else begin
      bus_q   <= BUS_NOP;
      sd_dqm  <= 1'b0;
      rd_pipe <= {rd_pipe[1:0], rd_left != 4'd0};
      if (rd_left != 4'd0) rd_left <= rd_left - 4'd1;
      if (wr_left != 4'd0) wr_left <= wr_left - 4'd1;
      if (trp_cnt != 4'd0) trp_cnt <= trp_cnt - 4'd1;
      if (mrd_cnt != '0)   mrd_cnt <= mrd_cnt - MRD_W'(1);
      if (acc) begin
        sd_ba   <= req_bank;
        sd_addr <= req_addr;
        case (req_cmd)
          CMD_ACT: begin
            bus_q <= BUS_ACT;
            bank_open[req_bank] <= 1'b1;
          end
          CMD_RD: begin
            bus_q   <= BUS_RD;
            rd_left <= burst_len;
          end
          CMD_WR: begin
            bus_q   <= BUS_WR;
            wr_left <= burst_len;
          end
          CMD_BST: begin
            bus_q   <= BUS_BST;
            rd_left <= '0;
            wr_left <= '0;
            sd_dqm  <= (wr_left > 4'd1);
          end
          CMD_PRE: begin
            bus_q   <= BUS_PRE;
            rd_left <= '0;
            trp_cnt <= trp_q;
            if (req_addr[10]) bank_open <= '0;
            else              bank_open[req_bank] <= 1'b0;
          end
          CMD_MRS: begin
            bus_q     <= BUS_MRS;
            bl_code_q <= req_addr[1:0];
            cl3_q     <= req_addr[4];
            trp_q     <= req_addr[11:8];
            mrd_cnt   <= MRD_W'(MRD_CLKS);
          end
          default: bus_q <= BUS_NOP;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       sd_cs_n,
  input logic       sd_ras_n,
  input logic       sd_cas_n,
  input logic       sd_we_n,
  input logic [1:0] sd_ba,
  input logic       sd_dqm,
  input logic       wr_beat,
  input logic [3:0] bank_open
);
  logic [3:0] bus;
  assign bus = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  a_r3_act_opens_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (bus == 4'b0011) |-> bank_open[sd_ba]);

  a_r5_mrs_banks_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus == 4'b0000) |-> (bank_open == 4'd0));

  a_r6_mrs_act_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (bus == 4'b0000) |=> (bus != 4'b0011));

  a_r7_pre_after_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (bus == 4'b0010) |-> !wr_beat);

  a_r8_dqm_only_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dqm |-> ((bus == 4'b0110) && !wr_beat));

  a_r11_held_gives_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (bus == 4'b0111));
endmodule

bind sdram_burst_seq sdram_burst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_ba(sd_ba), .sd_dqm(sd_dqm), .wr_beat(wr_beat), .bank_open(bank_open)
);

// File: tb/sdram_burst_seq_bench.sv
module sdram_burst_seq_bench;
  localparam int AW = 13;
  localparam logic [2:0] H_ACT = 1, H_RD = 2, H_WR = 3, H_BST = 4, H_PRE = 5, H_MRS = 6;
  localparam logic [3:0] B_NOP = 4'b0111, B_ACT = 4'b0011, B_RD = 4'b0101,
                         B_WR = 4'b0100, B_PRE = 4'b0010, B_MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [1:0] req_bank = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, wr_beat, rd_valid;
  logic [1:0] sd_ba;
  logic [AW-1:0] sd_addr;
  logic [3:0] bank_open;
  logic [3:0] bus;

  int checks = 0, fails = 0, cyc = 0;
  int t_rd = 0, t_wr = 0, t_pre = 0, t_mrs = 0, t_act = 0;
  logic [31:0] rv_mask = '0, wb_mask = '0, dq_mask = '0;

  always #10 clk = ~clk;
  assign bus = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  sdram_burst_seq #(.ADDR_W(AW), .RST_TRP(3)) u_sdram_burst_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_addr(req_addr), .req_ready(req_ready),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .wr_beat(wr_beat),
    .rd_valid(rd_valid), .bank_open(bank_open)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus == B_RD)  begin t_rd = cyc; rv_mask = '0; end
      if (bus == B_WR)  begin t_wr = cyc; wb_mask = '0; dq_mask = '0; end
      if (bus == B_PRE) t_pre = cyc;
      if (bus == B_MRS) t_mrs = cyc;
      if (bus == B_ACT) t_act = cyc;
      if (rd_valid && cyc >= t_rd && cyc - t_rd < 32) rv_mask[cyc - t_rd] = 1'b1;
      if (wr_beat  && cyc >= t_wr && cyc - t_wr < 32) wb_mask[cyc - t_wr] = 1'b1;
      if (sd_dqm   && cyc >= t_wr && cyc - t_wr < 32) dq_mask[cyc - t_wr] = 1'b1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c, input logic [1:0] b, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_bank = b; req_addr = a;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic probe(input logic [2:0] c, output logic r);
    @(negedge clk);
    req_valid = 1'b0; req_cmd = c; req_addr = '0;
    #1 r = req_ready;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic r;
    @(negedge clk);
    chk("R1 bus nop", int'(bus), int'(B_NOP));
    chk("R1 dqm", int'(sd_dqm), 0);
    chk("R1 wr_beat", int'(wr_beat), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 banks", int'(bank_open), 0);
    probe(H_MRS, r);
    chk("R1 mrs ready", int'(r), 1);
  endtask

  task automatic t_activate;
    send(H_ACT, 2'd1, 13'h0123);
    @(negedge clk);
    chk("R2 act code", int'(bus), int'(B_ACT));
    chk("R2 bank", int'(sd_ba), 1);
    chk("R2 addr", int'(sd_addr), 'h123);
    chk("R3 bank1 open", int'(bank_open), 4'b0010);
  endtask

  task automatic t_read_full;
    send(H_RD, 2'd1, 13'h0010);
    wait_n(12);
    chk("R9 bl4 cl3 valid mask", int'(rv_mask), 'h78);
  endtask

  task automatic t_read_pre;
    logic r;
    send(H_RD, 2'd1, '0);
    probe(H_WR, r);
    chk("R11 write held during read", int'(r), 0);
    send(H_PRE, 2'd1, '0);
    wait_n(10);
    chk("R10 cl3 precharge cut", int'(rv_mask), 'h18);
    chk("R3 bank1 closed", int'(bank_open), 0);
  endtask

  task automatic t_mode_gate;
    logic r;
    send(H_ACT, 2'd0, '0);
    send(H_ACT, 2'd3, '0);
    probe(H_MRS, r);
    chk("R5 mrs held banks open", int'(r), 0);
    chk("R3 banks 0 and 3", int'(bank_open), 4'b1001);
    send(H_PRE, 2'd0, 13'h0400);
    probe(H_MRS, r);
    chk("R5 mrs held in trp", int'(r), 0);
    chk("R3 precharge all", int'(bank_open), 0);
    send(H_MRS, 2'd0, 13'h0203);
    send(H_ACT, 2'd2, '0);
    wait_n(2);
    chk("R5 pre to mrs gap", t_mrs - t_pre, 3);
    chk("R6 mrs to act gap", t_act - t_mrs, 2);
    chk("R3 bank2 open", int'(bank_open), 4'b0100);
  endtask

  task automatic t_read_bst;
    send(H_RD, 2'd2, '0);
    wait_n(2);
    send(H_BST, 2'd2, '0);
    wait_n(12);
    chk("R10 R4 cl2 stop cut", int'(rv_mask), 'h1C);
  endtask

  task automatic t_write_bst;
    send(H_WR, 2'd2, '0);
    wait_n(3);
    send(H_BST, 2'd2, '0);
    wait_n(4);
    chk("R8 beats before stop", int'(wb_mask), 'h0F);
    chk("R8 dqm on stop", int'(dq_mask), 'h10);
  endtask

  task automatic t_write_pre;
    logic r;
    send(H_WR, 2'd2, '0);
    probe(H_RD, r);
    chk("R11 read held during write", int'(r), 0);
    send(H_PRE, 2'd2, '0);
    wait_n(3);
    chk("R7 write to pre gap", t_pre - t_wr, 8);
    chk("R7 full bl8 beats", int'(wb_mask), 'hFF);
    chk("R7 dqm quiet", int'(dq_mask), 0);
  endtask

  task automatic t_burst_one;
    send(H_PRE, 2'd0, 13'h0400);
    send(H_MRS, 2'd0, 13'h0210);
    send(H_RD, 2'd0, '0);
    wait_n(8);
    chk("R5 programmed trp gap", t_mrs - t_pre, 2);
    chk("R4 bl1 cl3 valid mask", int'(rv_mask), 'h08);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_activate;
    t_read_full;
    t_read_pre;
    t_mode_gate;
    t_read_bst;
    t_write_bst;
    t_write_pre;
    t_burst_one;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule